// File: doc/BRIEF.md
# Sixteen-Bit Timer and Falling-Edge Event Counter

The block holds a 16-bit count, split into a low and a high byte. It advances in one of two ways. In timer mode it gains one for every machine cycle of twelve oscillator clocks. In event mode it gains one for each falling edge seen on an external pin. A free-running phase counter divides each machine cycle into twelve oscillator steps. The pin is sampled once per machine cycle, late in the cycle. An edge counts when one sample reads high and the next reads low. The increment lands early in the following machine cycle. Because of this, the pin can be counted at most once every two machine cycles, which is one twenty-fourth of the oscillator rate.

Two sticky flags drive the interrupt line: a wrap flag and an external-event flag. They are set by hardware and cleared only by software. Software reaches both count bytes and a control byte through a small byte-wide register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `evt_timer16`

## Requirements
- R1: After reset the count is 0x0000, the control byte reads 0x00, `irq` is low and `phase` is 0.
- R2: Timer mode (control bit 1 = 0) with run (control bit 0 = 1): the count gains exactly one per machine cycle, on the clock edge where `phase` equals 2, and holds at every other edge.
- R3: With run cleared, the count holds in both modes, whatever the pin does.
- R4: Event mode (control bit 1 = 1) with run set: `cnt_pin` is sampled on the edge where `phase` is 9. A high sample followed by a low sample on the next machine cycle adds one. The new value appears on the edge where `phase` is 2 in the next machine cycle. Steady levels add nothing. The sampler starts from a low level at reset.
- R5: A pin toggling every machine cycle is counted once per two machine cycles. A low pulse that does not cover the sampling phase is not counted.
- R6: An increment from 0xFFFF gives 0x0000 and sets the wrap flag (control bit 7) on the same edge.
- R7: A high level on `ext_evt` at a clock edge sets the external flag (control bit 6).
- R8: `irq` is high exactly when the wrap flag or the external flag is set.
- R9: Flags stay set until control is written with that bit at 0. A hardware set in the same cycle as such a write wins.
- R10: A write to either count byte in the cycle of an increment stores the written byte, leaves the other byte alone and drops the increment.
- R11: `phase` steps 0,1,…,11 and wraps to 0, one step per clock.
- R12: Register addresses: 0 is the low count byte, 1 is the high count byte, 2 is control, and 3 reads as zero. Control bits 5:2 are stored and read back but have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_pin | input | 1 | External event pin, counted on falling edges |
| ext_evt | input | 1 | Sets the external flag while high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |
| phase | output | 4 | Oscillator step within the machine cycle |

## Verification
Two pairs of functions can land on the same edge.

- **Byte write against increment.** The bench aligns to `phase` 2 with counting enabled. It then writes the low count byte in that very clock. It judges the result by reading the byte back as the written value, with the high byte unchanged.
- **Flag clear against wrap.** The bench preloads 0xFFFF and issues a control write that clears the flags on the wrapping edge. It expects the wrap flag and `irq` to read set afterwards.

Event counting is swept over every 8-bit pattern of per-cycle pin levels. The expected total comes from counting high-to-low pairs.

// File: rtl/evt_timer16.sv
module evt_timer16 #(
  parameter int CYC_LEN = 12,
  parameter int SMP_PH  = 9,
  parameter int UPD_PH  = 2,
  parameter int PW      = $clog2(CYC_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_pin,
  input  logic          ext_evt,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  output logic          irq,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] LAST = PW'(CYC_LEN - 1);

  logic [PW-1:0] ph_q;
  logic [15:0]   cnt_q;
  logic [5:0]    ctl_q;
  logic          ovf_q, ext_q, smp_q, pend_q;

  wire wr_lo  = wr_en && addr == 2'd0;
  wire wr_hi  = wr_en && addr == 2'd1;
  wire wr_ctl = wr_en && addr == 2'd2;
  wire at_smp = ph_q == PW'(SMP_PH);
  wire at_upd = ph_q == PW'(UPD_PH);
  wire tick   = ctl_q[0] && at_upd && (ctl_q[1] ? pend_q : 1'b1);
  wire bump   = tick && !wr_lo && !wr_hi;
  wire wrap   = bump && cnt_q == 16'hFFFF;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            ph_q <= '0;
    else if (ph_q == LAST) ph_q <= '0;
    else                   ph_q <= ph_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      smp_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (at_smp) begin
      smp_q  <= cnt_pin;
      pend_q <= smp_q & ~cnt_pin;
    end else if (at_upd) begin
      pend_q <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_q[7:0]  <= wr_data;
      if (wr_hi) cnt_q[15:8] <= wr_data;
    end else if (bump) cnt_q <= cnt_q + 16'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_q <= '0;
      ovf_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= wr_data[5:0];
      ovf_q <= (wr_ctl ? wr_data[7] : ovf_q) | wrap;
      ext_q <= (wr_ctl ? wr_data[6] : ext_q) | ext_evt;
    end

  always_comb
    case (addr)
      2'd0:    rd_data = cnt_q[7:0];
      2'd1:    rd_data = cnt_q[15:8];
      2'd2:    rd_data = {ovf_q, ext_q, ctl_q};
      default: rd_data = 8'h00;
    endcase

  assign irq   = ovf_q | ext_q;
  assign phase = ph_q;
endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
  parameter int CYC_LEN = 12,
  parameter int UPD_PH  = 2,
  parameter int PW      = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] phase,
  input logic [15:0]   cnt,
  input logic          ovf,
  input logic          run,
  input logic          irq,
  input logic          wr_en,
  input logic [1:0]    addr
);
  wire cw = wr_en && addr[1] == 1'b0;
  wire fw = wr_en && addr == 2'd2;

  p_phase_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PW'(CYC_LEN - 1) |=> phase == '0);
  p_phase_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    phase != PW'(CYC_LEN - 1) |=> phase == PW'($past(phase) + 1'b1));
  p_upd_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PW'(UPD_PH)) && !cw |=> $stable(cnt));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cw |=> (cnt == $past(cnt)) || (cnt == 16'($past(cnt) + 16'd1)));
  p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cw |=> $stable(cnt));
  p_wrap_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 16'hFFFF && !cw) ##1 (cnt == 16'h0000) |-> ovf);
  p_ovf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !fw |=> ovf);
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !fw |=> irq);
endmodule

bind evt_timer16 evt_timer16_chk #(.CYC_LEN(CYC_LEN), .UPD_PH(UPD_PH), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .phase(phase), .cnt(cnt_q), .ovf(ovf_q),
  .run(ctl_q[0]), .irq(irq), .wr_en(wr_en), .addr(addr)
);

// File: tb/evt_timer16_tb_top.sv
`timescale 1ns/1ps
module evt_timer16_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cnt_pin = 1'b0, ext_evt = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic irq;
  logic [3:0] phase;
  int checks = 0, errors = 0;

  evt_timer16 dut_i (.clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .ext_evt(ext_evt),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .irq(irq), .phase(phase));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rd_data;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd0, lo); rd(2'd1, hi); v = {hi, lo};
  endtask

  task automatic wait_ph(input int p);
    while (phase != 4'(p)) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [15:0] c, c0;
    int expc;
    logic prev;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    rd16(c); chk(c == 0, "R1 count", c, 0);
    rd(2'd2, b); chk(b == 0, "R1 control", b, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(phase == 0, "R1 phase", phase, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 phase sequence
    for (int i = 0; i < 30; i++) begin
      automatic int p0 = phase;
      @(negedge clk);
      chk(phase == 4'((p0 + 1) % 12), "R11 phase step", phase, (p0 + 1) % 12);
    end
    // R12 address 3 reads zero, spare bits read back
    rd(2'd3, b); chk(b == 0, "R12 addr3", b, 0);
    wr(2'd2, 8'h3C); rd(2'd2, b); chk(b == 8'h3C, "R12 spare bits", b, 8'h3C);
    wr(2'd2, 8'h00);
    // R3 timer stopped
    repeat (60) @(negedge clk);
    rd16(c); chk(c == 0, "R3 stopped timer", c, 0);
    // R2 timer counts once per machine cycle
    wr(2'd2, 8'h01);
    wait_ph(2); @(negedge clk); rd16(c0);
    for (int n = 1; n <= 20; n++) begin
      repeat (11) @(negedge clk);
      rd16(c); chk(c == c0 + 16'(n - 1), "R2 hold before update", c, c0 + n - 1);
      @(negedge clk);
      rd16(c); chk(c == c0 + 16'(n), "R2 per cycle", c, c0 + n);
    end
    // R10 byte write against increment
    wait_ph(2); rd16(c0);
    wr(2'd0, 8'h55);
    rd16(c); chk(c == {c0[15:8], 8'h55}, "R10 write wins", c, {c0[15:8], 8'h55});
    wr(2'd2, 8'h00);
    // R6/R8 wrap
    wr(2'd1, 8'hFF); wr(2'd0, 8'hFE); wr(2'd2, 8'h01);
    wait_ph(2); @(negedge clk);
    rd16(c); chk(c == 16'hFFFF, "R6 pre-wrap", c, 16'hFFFF);
    chk(irq == 0, "R8 irq low", irq, 0);
    wait_ph(2); @(negedge clk);
    rd16(c); chk(c == 0, "R6 wrap value", c, 0);
    rd(2'd2, b); chk(b[7] == 1, "R6 wrap flag", b, 8'h81);
    chk(irq == 1, "R8 irq from wrap", irq, 1);
    // R9 sticky, then software clear
    repeat (40) @(negedge clk);
    rd(2'd2, b); chk(b[7] == 1, "R9 flag sticky", b, 8'h81);
    wr(2'd2, 8'h01);
    rd(2'd2, b); chk(b[7] == 0, "R9 flag cleared", b, 8'h01);
    chk(irq == 0, "R9 irq cleared", irq, 0);
    // R9 hardware set beats simultaneous clear
    wr(2'd2, 8'h00); wr(2'd1, 8'hFF); wr(2'd0, 8'hFF); wr(2'd2, 8'h01);
    wait_ph(2);
    wr(2'd2, 8'h01);
    rd(2'd2, b); chk(b[7] == 1, "R9 set wins over clear", b, 8'h81);
    chk(irq == 1, "R9 irq after collision", irq, 1);
    wr(2'd2, 8'h00);
    chk(irq == 0, "R8 irq both clear", irq, 0);
    // R7 external flag
    ext_evt = 1'b1; @(negedge clk); ext_evt = 1'b0;
    rd(2'd2, b); chk(b[6] == 1, "R7 ext flag", b, 8'h40);
    chk(irq == 1, "R8 irq from ext", irq, 1);
    repeat (30) @(negedge clk);
    rd(2'd2, b); chk(b[6] == 1, "R9 ext sticky", b, 8'h40);
    wr(2'd2, 8'h00); chk(irq == 0, "R9 ext cleared", irq, 0);
    // R4 event timing
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h03);
    wait_ph(0); cnt_pin = 1'b1; @(negedge clk);
    wait_ph(0); cnt_pin = 1'b0; @(negedge clk);
    wait_ph(9); @(negedge clk);
    wait_ph(2);
    rd16(c); chk(c == 0, "R4 not yet visible", c, 0);
    @(negedge clk);
    rd16(c); chk(c == 1, "R4 visible next cycle", c, 1);
    repeat (50) @(negedge clk);
    rd16(c); chk(c == 1, "R4 steady low", c, 1);
    // R5 short low pulse missing the sample phase
    wait_ph(0); cnt_pin = 1'b1; @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      wait_ph(0); cnt_pin = 1'b0; wait_ph(5); cnt_pin = 1'b1;
    end
    wait_ph(0); @(negedge clk); wait_ph(0); @(negedge clk); wait_ph(3);
    rd16(c); chk(c == 1, "R5 short pulses ignored", c, 1);
    // R3 event mode stopped
    wr(2'd2, 8'h02);
    for (int k = 0; k < 6; k++) begin
      wait_ph(0); cnt_pin = ~cnt_pin; @(negedge clk);
    end
    wait_ph(0); @(negedge clk); wait_ph(0); @(negedge clk); wait_ph(3);
    rd16(c); chk(c == 1, "R3 stopped events", c, 1);
    // R4/R5 sweep of all per-cycle level patterns
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h03);
    prev = cnt_pin; expc = 0;
    for (int p = 0; p < 256; p++) begin
      for (int k = 0; k < 8; k++) begin
        automatic logic lvl = 1'(p >> k);
        wait_ph(0); cnt_pin = lvl;
        if (prev && !lvl) expc++;
        prev = lvl;
        @(negedge clk);
      end
      wait_ph(0); @(negedge clk); wait_ph(0); @(negedge clk); wait_ph(3);
      rd16(c);
      chk(c == 16'(expc), (p == 8'hAA || p == 8'h55) ? "R5 max rate" : "R4 sweep", c, expc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule